// File: doc/BRIEF.md
# CPU-Driven FIFO Window Bridge

This bridge lets a processor act as the DMA engine for the byte-wide data FIFO of a SCSI protocol controller. It decodes a window in the controller's address space. Every processor read or write that lands in the window performs request/acknowledge handshakes against the controller's FIFO. The bridge holds the bus cycle open while it waits for the controller's data request. If the request does not arrive in time, it ends the cycle with a bus error instead of waiting forever. A stall of this kind happens when a write meets a full FIFO that is not draining, when a read meets an empty FIFO that is not filling, or when the controller has raised an interrupt. Software then checks bit 7 of the controller status register for a pending interrupt, or polls the live request level, and retries.

The window repeats every four bytes. Within each four-byte slot, only the halfword at offsets 0 and 1 carries data. The halfword at offsets 2 and 3 still consumes handshakes but carries filler bytes. A halfword access moves two FIFO bytes, and a byte access moves one, which is how a trailing odd byte is handled. A 12-bit timing register sets the recovery gap between handshakes. Reading that register also returns the live request level.

Top module: `pdma_bridge`

## Requirements
- R1: After reset, cpu_ack, cpu_berr and ctl_dack are low, and the timing register holds 0x1D1.
- R2: An access to the timing-register address completes with cpu_ack one cycle after acceptance and moves no FIFO byte. A write stores cpu_wdata[11:0]. A read returns the stored value in bits 11:0, except that bit 9 shows the live ctl_dreq level; bits 15:12 read as zero.
- R3: Any address whose bits 11:8 equal 0x1 belongs to the window. Bit 0 of the address is ignored, and every four-byte slot reaches the same FIFO port.
- R4: A halfword access (cpu_half=1) performs two handshakes, and a byte access performs one. For a halfword, the first byte transferred is data bits 15:8 and the second is bits 7:0. A byte access uses bits 7:0, and bits 15:8 read as zero.
- R5: When address bit 1 is 1, the access is a filler access. It performs the same handshakes, drives 0xFF into the FIFO on writes, and returns 0xFFFF (halfword) or 0x00FF (byte) on reads.
- R6: ctl_dack is a one-cycle strobe. It is raised only in the cycle after ctl_dreq was sampled high. ctl_wr is 1 for a processor write and 0 for a read.
- R7: The two strobes of one halfword start 2 + G cycles apart, where G is timing-register bits 3:0.
- R8: cpu_ack is raised the cycle after the last strobe. With ctl_dreq already high, a byte access completes 3 cycles after acceptance and a halfword access 5 + G cycles after acceptance.
- R9: If ctl_dreq stays low for TMO_CYC consecutive waiting cycles, the access ends with a one-cycle cpu_berr and moves no further byte. With no byte moved, cpu_berr appears TMO_CYC + 1 cycles after acceptance.
- R10: The wait counter restarts at the beginning of each access and again after each strobe. Each byte of a halfword therefore gets its own full timeout window.
- R11: If a halfword access fails after its first byte, the bridge keeps that byte. The next halfword window access in the same direction moves only the second byte. A read returns the kept byte in bits 15:8. A write sends bits 7:0 of the new data.
- R12: A kept partial halfword is dropped by any window access that is not a halfword in the same direction; that access then runs normally. Timing-register and unmapped accesses leave it intact.
- R13: An access outside both the window and the timing register completes with cpu_ack one cycle after acceptance, returns zero and moves no FIFO byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until cpu_ack or cpu_berr |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_half | input | 1 | 1 = halfword, 0 = byte |
| cpu_addr | input | ADDR_W | Access address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_berr | output | 1 | One-cycle bus-error pulse |
| ctl_dreq | input | 1 | Controller data request |
| ctl_dack | output | 1 | One-cycle data acknowledge strobe |
| ctl_wr | output | 1 | Direction of the strobe, 1 = into the FIFO |
| ctl_dout | output | 8 | Byte pushed into the FIFO, valid with ctl_dack |
| ctl_din | input | 8 | FIFO head byte, sampled at the end of the strobe cycle |

## Verification
An internal fault shows up at the ports in one of three ways:

- **Strobe count:** a wrong byte index or halfword flag changes how many strobes an access takes, visible before its completion pulse.
- **Byte order or latency:** a wrong recovery count shifts the strobe spacing and the completion cycle.
- **Timeout or partial state:** a wrong wait counter moves the bus-error cycle, or turns a slow access into an error. A corrupted partial-halfword state shows only on the next window access, as a missing or extra strobe or a wrong high byte.

The bench sweeps every size, direction, lane and gap value 0 to 3 over many slots, and checks cycle counts exactly.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int CFG_W    = 12;
    localparam int GAP_W    = 4;
    localparam int DREQ_BIT = 9;
    localparam int DATA_W   = 16;
    localparam logic [CFG_W-1:0] CFG_RST = 12'h1D1;

    typedef enum logic [1:0] {
        REGION_NONE,
        REGION_WIN,
        REGION_CFG
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_RECOV
    } xfer_st_e;

    typedef struct packed {
        logic              we;
        logic              half;
        logic              filler;
        logic [DATA_W-1:0] wdata;
    } access_s;

    // Byte presented to the FIFO for byte position idx of an access.
    function automatic logic [7:0] push_byte(input logic [DATA_W-1:0] w,
                                             input logic half,
                                             input logic idx,
                                             input logic filler);
        if (filler)
            return 8'hFF;
        if (half && !idx)
            return w[15:8];
        return w[7:0];
    endfunction

    // Read word returned to the processor.
    function automatic logic [DATA_W-1:0] pull_word(input logic half,
                                                    input logic filler,
                                                    input logic [7:0] first,
                                                    input logic [7:0] last);
        if (filler)
            return half ? 16'hFFFF : 16'h00FF;
        return half ? {first, last} : {8'h00, last};
    endfunction

endpackage

// File: rtl/pdma_decode.sv
module pdma_decode
    import pdma_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h100,
    parameter int                WIN_LG   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h0C0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              filler
);

    logic unused_lsb;
    assign unused_lsb = addr[0];

    always_comb begin
        if (addr[ADDR_W-1:WIN_LG] == WIN_BASE[ADDR_W-1:WIN_LG])
            region = REGION_WIN;
        else if (addr[ADDR_W-1:2] == CFG_ADDR[ADDR_W-1:2])
            region = REGION_CFG;
        else
            region = REGION_NONE;
    end

    // Offsets 2..3 of each four-byte slot are the filler half.
    assign filler = addr[1];

endmodule

// File: rtl/pdma_cfg.sv
module pdma_cfg
    import pdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_val,
    input  logic             dreq,
    output logic [CFG_W-1:0] rd_val,
    output logic [GAP_W-1:0] gap
);

    logic [CFG_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= CFG_RST;
        else if (wr_en)
            q <= wr_val;
    end

    always_comb begin
        rd_val           = q;
        rd_val[DREQ_BIT] = dreq;
    end

    assign gap = q[GAP_W-1:0];

endmodule

// File: rtl/pdma_timeout.sv
module pdma_timeout #(
    parameter int TMO_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(TMO_CYC - 1));

    // R9
    tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(TMO_CYC));

endmodule

// File: rtl/pdma_bridge.sv
module pdma_bridge
    import pdma_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'h100,
    parameter int                WIN_LG   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 'h0C0,
    parameter int                TMO_CYC  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_half,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_berr,
    input  logic              ctl_dreq,
    output logic              ctl_dack,
    output logic              ctl_wr,
    output logic [7:0]        ctl_dout,
    input  logic [7:0]        ctl_din
);

    region_e          region;
    logic             win_filler;
    logic [CFG_W-1:0] cfg_rd;
    logic [GAP_W-1:0] gap;
    logic             cfg_wr;
    logic             tmo_expired;

    xfer_st_e         st;
    access_s          cur;
    logic             idx;
    logic [GAP_W-1:0] gap_cnt;
    logic [7:0]       first_byte;
    logic             partial;
    logic             partial_we;
    logic             resume;

    pdma_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_LG  (WIN_LG),
        .CFG_ADDR(CFG_ADDR)
    ) u_decode (
        .addr  (cpu_addr),
        .region(region),
        .filler(win_filler)
    );

    assign cfg_wr = (st == ST_IDLE) && cpu_req && cpu_we && (region == REGION_CFG);

    pdma_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cfg_wr),
        .wr_val(cpu_wdata[CFG_W-1:0]),
        .dreq  (ctl_dreq),
        .rd_val(cfg_rd),
        .gap   (gap)
    );

    pdma_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .run    (st == ST_WAIT),
        .expired(tmo_expired)
    );

    assign resume = partial && cpu_half && (cpu_we == partial_we);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur        <= '0;
            idx        <= 1'b0;
            gap_cnt    <= '0;
            first_byte <= '0;
            partial    <= 1'b0;
            partial_we <= 1'b0;
            cpu_rdata  <= '0;
            cpu_ack    <= 1'b0;
            cpu_berr   <= 1'b0;
            ctl_dack   <= 1'b0;
            ctl_wr     <= 1'b0;
            ctl_dout   <= '0;
        end else begin
            cpu_ack  <= 1'b0;
            cpu_berr <= 1'b0;
            ctl_dack <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (cpu_req) begin
                        unique case (region)
                            REGION_CFG: begin
                                cpu_rdata <= {{(DATA_W-CFG_W){1'b0}}, cfg_rd};
                                cpu_ack   <= 1'b1;
                            end
                            REGION_WIN: begin
                                cur     <= '{we: cpu_we, half: cpu_half,
                                             filler: win_filler, wdata: cpu_wdata};
                                idx     <= resume;
                                partial <= 1'b0;
                                st      <= ST_WAIT;
                            end
                            default: begin
                                cpu_rdata <= '0;
                                cpu_ack   <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (ctl_dreq) begin
                        ctl_dack <= 1'b1;
                        ctl_wr   <= cur.we;
                        ctl_dout <= push_byte(cur.wdata, cur.half, idx, cur.filler);
                        st       <= ST_XFER;
                    end else if (tmo_expired) begin
                        cpu_berr <= 1'b1;
                        st       <= ST_IDLE;
                        if (idx) begin
                            partial    <= 1'b1;
                            partial_we <= cur.we;
                        end
                    end
                end
                ST_XFER: begin
                    if (cur.half && !idx) begin
                        if (!cur.we)
                            first_byte <= ctl_din;
                        idx <= 1'b1;
                        if (gap != '0) begin
                            gap_cnt <= gap;
                            st      <= ST_RECOV;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end else begin
                        cpu_rdata <= pull_word(cur.half, cur.filler, first_byte, ctl_din);
                        cpu_ack   <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                ST_RECOV: begin
                    gap_cnt <= gap_cnt - 1'b1;
                    if (gap_cnt == GAP_W'(1))
                        st <= ST_WAIT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6
    dack_after_dreq_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_dack |-> $past(ctl_dreq));

    // R6
    dack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_dack |=> !ctl_dack);

    // R9
    berr_after_low_dreq_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_berr |-> !$past(ctl_dreq));

    // R8
    done_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_ack, cpu_berr}));

    // R9
    berr_no_dack_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_berr |-> !ctl_dack);

endmodule

// File: tb/tb_pdma_bridge.sv
`timescale 1ns/1ps
module tb_pdma_bridge;

    localparam int TMO = 12;
    localparam logic [11:0] CFG_A = 12'h0C0;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic        cpu_half = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack;
    logic        cpu_berr;
    logic        ctl_dreq;
    logic        ctl_dack;
    logic        ctl_wr;
    logic [7:0]  ctl_dout;
    logic [7:0]  din_q = 8'h21;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dk_cnt = 0;
    int dk_last = 0;
    int dk_prev = 0;
    int dreq_limit = 0;
    int wn = 0;
    logic [7:0] wlog [0:1023];

    always #4 clk = ~clk;

    assign ctl_dreq = (dreq_limit > dk_cnt);

    pdma_bridge #(.TMO_CYC(TMO), .CFG_ADDR(CFG_A)) dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_half(cpu_half),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .cpu_berr(cpu_berr),
        .ctl_dreq(ctl_dreq), .ctl_dack(ctl_dack), .ctl_wr(ctl_wr),
        .ctl_dout(ctl_dout), .ctl_din(din_q)
    );

    // Controller FIFO model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ctl_dack) begin
            dk_prev <= dk_last;
            dk_last <= cyc;
            dk_cnt  <= dk_cnt + 1;
            if (ctl_wr) begin
                wlog[wn[9:0]] <= ctl_dout;
                wn <= wn + 1;
            end else begin
                din_q <= din_q + 8'd7;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic half, input logic [11:0] a,
                          input logic [15:0] wd, output logic [15:0] rd,
                          output logic ok, output logic be, output int lat);
        cpu_req = 1'b1; cpu_we = we; cpu_half = half; cpu_addr = a; cpu_wdata = wd;
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (cpu_ack || cpu_berr || lat > 5000) break;
        end
        ok = cpu_ack; be = cpu_berr; rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic set_partial_read();
        logic [15:0] rd; logic ok, be; int lat, b;
        b = dk_cnt;
        dreq_limit = dk_cnt + 1;
        access(1'b0, 1'b1, 12'h108, 16'h0, rd, ok, be, lat);
        chk("R11 partial setup berr", {31'd0, be}, 32'd1);
        chk("R11 partial setup one strobe", dk_cnt - b, 32'd1);
        dreq_limit = dk_cnt + 100000;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd, wd;
        logic ok, be;
        int lat, b, w0;
        logic [7:0] d0;

        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ack low", {31'd0, cpu_ack}, 32'd0);
        chk("R1 berr low", {31'd0, cpu_berr}, 32'd0);
        chk("R1 dack low", {31'd0, ctl_dack}, 32'd0);
        dreq_limit = dk_cnt;
        access(1'b0, 1'b1, CFG_A, 16'h0, rd, ok, be, lat);
        chk("R1 cfg reset value", rd, 16'h01D1);
        chk("R2 cfg latency", lat, 32'd1);
        dreq_limit = dk_cnt + 100000;
        access(1'b0, 1'b1, CFG_A, 16'h0, rd, ok, be, lat);
        chk("R2 cfg live dreq bit9", rd, 16'h03D1);

        // R2 write then read with dreq low and high
        b = dk_cnt;
        access(1'b1, 1'b1, CFG_A, 16'hFABC, rd, ok, be, lat);
        chk("R2 cfg write ack", {31'd0, ok}, 32'd1);
        dreq_limit = dk_cnt;
        access(1'b0, 1'b1, CFG_A + 12'd2, 16'h0, rd, ok, be, lat);
        chk("R2 cfg read dreq low", rd, 16'h0ABC & ~16'h0200);
        dreq_limit = dk_cnt + 100000;
        access(1'b0, 1'b1, CFG_A, 16'h0, rd, ok, be, lat);
        chk("R2 cfg read dreq high", rd, 16'h0ABC | 16'h0200);
        chk("R2 cfg moves no byte", dk_cnt - b, 32'd0);

        // R13 unmapped
        b = dk_cnt; w0 = wn;
        access(1'b0, 1'b1, 12'h300, 16'h0, rd, ok, be, lat);
        chk("R13 unmapped ack", {31'd0, ok}, 32'd1);
        chk("R13 unmapped latency", lat, 32'd1);
        chk("R13 unmapped rdata", rd, 16'h0);
        access(1'b1, 1'b0, 12'h2A0, 16'h5555, rd, ok, be, lat);
        chk("R13 unmapped no strobe", dk_cnt - b, 32'd0);
        chk("R13 unmapped no push", wn - w0, 32'd0);

        // Sweep: gap x direction x size x lane over many slots (R3..R8)
        for (int g = 0; g < 4; g++) begin
            access(1'b1, 1'b1, CFG_A, 16'h01D0 | 16'(g), rd, ok, be, lat);
            for (int k = 0; k < 8; k++) begin
                logic we_k, half_k, lane_k;
                logic [11:0] a;
                we_k = k[0]; half_k = k[1]; lane_k = k[2];
                a = 12'h100 | 12'(((g * 8 + k) * 4) & 8'hFC) | {10'd0, lane_k, 1'b0}
                    | {11'd0, (!half_k) & g[0]};
                wd = {8'(8'h40 + g * 8 + k), 8'(8'h90 + g * 3 + k)};
                d0 = din_q; b = dk_cnt; w0 = wn;
                access(we_k, half_k, a, wd, rd, ok, be, lat);
                chk("R3 window ack", {31'd0, ok}, 32'd1);
                chk("R4 strobe count", dk_cnt - b, half_k ? 32'd2 : 32'd1);
                chk("R8 latency", lat, half_k ? 32'(5 + g) : 32'd3);
                if (half_k)
                    chk("R7 strobe spacing", dk_last - dk_prev, 32'(2 + g));
                if (we_k) begin
                    chk("R6 write pushes", wn - w0, half_k ? 32'd2 : 32'd1);
                    if (lane_k) begin
                        chk("R5 filler push", wlog[w0[9:0]], 8'hFF);
                    end else if (half_k) begin
                        chk("R4 first byte high", wlog[w0[9:0]], wd[15:8]);
                        chk("R4 second byte low", wlog[10'(w0 + 1)], wd[7:0]);
                    end else begin
                        chk("R4 byte write", wlog[w0[9:0]], wd[7:0]);
                    end
                end else begin
                    chk("R6 read pushes none", wn - w0, 32'd0);
                    if (lane_k)
                        chk("R5 filler read", rd, half_k ? 16'hFFFF : 16'h00FF);
                    else if (half_k)
                        chk("R4 read order", rd, {d0, 8'(d0 + 8'd7)});
                    else
                        chk("R4 byte read", rd, {8'h00, d0});
                end
            end
        end
        access(1'b1, 1'b1, CFG_A, 16'h01D1, rd, ok, be, lat);

        // R9 timeout with no strobe
        b = dk_cnt; w0 = wn;
        dreq_limit = dk_cnt;
        access(1'b1, 1'b1, 12'h100, 16'hBEEF, rd, ok, be, lat);
        chk("R9 write berr", {31'd0, be}, 32'd1);
        chk("R9 berr latency", lat, 32'(TMO + 1));
        chk("R9 no push", wn - w0, 32'd0);
        d0 = din_q;
        access(1'b0, 1'b0, 12'h1F4, 16'h0, rd, ok, be, lat);
        chk("R9 read berr", {31'd0, be}, 32'd1);
        chk("R9 no pop", {24'd0, din_q}, {24'd0, d0});
        chk("R9 no strobe", dk_cnt - b, 32'd0);

        // R10 restart of wait counter per byte
        b = dk_cnt;
        dreq_limit = b;
        fork
            access(1'b0, 1'b1, 12'h140, 16'h0, rd, ok, be, lat);
            begin
                repeat (TMO - 3) @(negedge clk);
                dreq_limit = b + 1;
                wait (dk_cnt == b + 1);
                repeat (TMO - 3) @(negedge clk);
                dreq_limit = b + 100000;
            end
        join
        chk("R10 slow halfword acks", {31'd0, ok}, 32'd1);
        chk("R10 both bytes moved", dk_cnt - b, 32'd2);

        // R11 read resume
        d0 = din_q;
        set_partial_read();
        b = dk_cnt;
        access(1'b0, 1'b1, 12'h1A0, 16'h0, rd, ok, be, lat);
        chk("R11 resume one strobe", dk_cnt - b, 32'd1);
        chk("R11 resume data", rd, {d0, 8'(d0 + 8'd7)});
        chk("R11 resume latency", lat, 32'd3);

        // R11 write resume
        w0 = wn;
        dreq_limit = dk_cnt + 1;
        access(1'b1, 1'b1, 12'h104, 16'h1234, rd, ok, be, lat);
        chk("R11 write partial berr", {31'd0, be}, 32'd1);
        chk("R11 write first byte", wlog[w0[9:0]], 8'h12);
        dreq_limit = dk_cnt + 100000;
        access(1'b1, 1'b1, 12'h104, 16'h5678, rd, ok, be, lat);
        chk("R11 write resume count", wn - w0, 32'd2);
        chk("R11 write second byte", wlog[10'(w0 + 1)], 8'h78);

        // R12 timing-register access keeps the partial state
        set_partial_read();
        access(1'b0, 1'b1, CFG_A, 16'h0, rd, ok, be, lat);
        b = dk_cnt;
        access(1'b0, 1'b1, 12'h100, 16'h0, rd, ok, be, lat);
        chk("R12 cfg keeps partial", dk_cnt - b, 32'd1);

        // R12 byte access discards the partial state
        set_partial_read();
        d0 = din_q; b = dk_cnt;
        access(1'b0, 1'b0, 12'h100, 16'h0, rd, ok, be, lat);
        chk("R12 byte runs normally", rd, {8'h00, d0});
        access(1'b0, 1'b1, 12'h100, 16'h0, rd, ok, be, lat);
        chk("R12 partial dropped", dk_cnt - b, 32'd3);

        // R12 opposite direction discards the partial state
        set_partial_read();
        b = dk_cnt;
        access(1'b1, 1'b1, 12'h100, 16'hA55A, rd, ok, be, lat);
        chk("R12 direction mismatch full", dk_cnt - b, 32'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule